// File: doc/BRIEF.md
# Store-Versus-Fetch Code Hazard Detector

This block sits beside an in-order pipeline of seven stages (fetch, decode, register read, address generation, operand read, execute, write-back) and catches writes to code. Data stores update memory only in the final stage, while instruction bytes are fetched in the first. When a store commits, up to six younger instructions can therefore already have been fetched, and their bytes may be stale. The block compares every committing store byte against the byte ranges of the instructions held in the six younger stages. It also compares the store against a small direct-mapped table of valid instruction-cache line tags.

A store that lands in a cached code line produces a same-cycle line invalidate, so that later fetches read the new bytes. A store that lands in an in-flight instruction produces a one-cycle flush request on the next clock. The request carries the restart address of the oldest instruction hit and a mask of the stages to discard. It also carries a two-bit class that tells whether the opcode halfword, the extension (immediate) bytes, or both were written. A store to code that is far ahead of fetch only invalidates the line and never stalls.

The cache data array, instruction decode and any forwarding of store data into fetched bytes belong to other blocks. The refill path reports each newly filled line to this block on a line-number input, so that the tag table mirrors the cache contents.

Top module: `smc_hazard_det`

## Requirements
- R1: In a cycle with `st_commit` high, `inv_vld` is high in the same cycle, with `inv_line` = `st_addr[31:4]`, exactly when that 16-byte line is valid in the tag table with a matching tag. The table is indexed by line bits [2:0]. A different line that aliases to the same index gives no invalidate.
- R2: `fill_vld` with `fill_line` marks that line valid from the next cycle. An invalidate clears the line. When a fill and an invalidate target the same line in one cycle, the line ends invalid.
- R3: The store writes byte `st_addr+k` only when `st_be[k]` is set and k is below the store size. `st_size` 0 means 1 byte, 1 means 2 bytes, 2 or 3 means 4 bytes. Byte enables beyond the size are ignored.
- R4: Stage i (0 = fetch, 5 = oldest tracked) holds an instruction of 2×`stg_hw[3i+2:3i]` bytes starting at `stg_addr[32i+31:32i]`. Its opcode is the first two bytes and its extension words are the rest. A stage whose `stg_vld[i]` bit is low never matches.
- R5: A committing store that writes any byte of a valid in-flight instruction raises `flush` in the cycle after the commit, for exactly one cycle.
- R6: `flush_addr` is the start address of the overlapped stage with the highest index, which is the oldest instruction hit.
- R7: `flush_kill` has bits 0 through j set, where j is the oldest overlapped stage. All other bits are clear.
- R8: `hz_class` describes the oldest overlapped stage: 2'b01 extension bytes only, 2'b10 opcode bytes only, 2'b11 both. It reads 2'b00 whenever `flush` is low.
- R9: A store that commits in a cycle where `flush` is high is still checked against the tag table and can still invalidate a line. It never causes a flush.
- R10: After reset, `flush` is 0, `hz_class` is 0, `flush_kill` is 0, `flush_addr` is 0, and every line in the tag table is invalid.
- R11: A store that touches no byte of any valid in-flight instruction causes no flush, whatever line it invalidates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_commit | input | 1 | A data store commits this cycle |
| st_addr | input | 32 | Byte address of the store, aligned to its size |
| st_size | input | 2 | Store size: 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes |
| st_be | input | 4 | Byte enables relative to st_addr |
| stg_vld | input | 6 | Instruction-present flag per tracked stage |
| stg_addr | input | 192 | Start address per stage, 32 bits each, stage 0 lowest |
| stg_hw | input | 18 | Length per stage in halfwords (1 to 5), 3 bits each |
| fill_vld | input | 1 | Instruction-cache refill of a line this cycle |
| fill_line | input | 28 | Line number (address bits 31:4) being filled |
| inv_vld | output | 1 | Invalidate one instruction-cache line |
| inv_line | output | 28 | Line number to invalidate |
| flush | output | 1 | Pipeline flush request, one cycle |
| flush_addr | output | 32 | Restart fetch address |
| flush_kill | output | 6 | Stages whose contents must be discarded |
| hz_class | output | 2 | Overlap class of the oldest hit instruction |

## Verification
Two functions can fall in the same cycle: the pipeline overlap check of a store and a flush request still in progress from the store before it. The bench provokes this by committing one store that hits the oldest stage and, in the very next cycle, a second store that also hits an in-flight instruction and a cached line. The second store must produce its line invalidate in its own cycle and no flush in the cycle after. The bench also lines up a refill and an invalidating store on the same line in one cycle. It judges that case by whether a later store to that line still invalidates.

// File: rtl/smc_pkg.sv
package smc_pkg;

  localparam int unsigned ADDR_W   = 32;
  localparam int unsigned N_STAGE  = 6;
  localparam int unsigned HW_W     = 3;
  localparam int unsigned ST_BYTES = 4;

  typedef enum logic [1:0] {
    HZ_NONE = 2'b00,
    HZ_IMM  = 2'b01,
    HZ_OPC  = 2'b10,
    HZ_BOTH = 2'b11
  } hz_class_e;

  function automatic logic [ST_BYTES-1:0] size_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    size_mask = 4'b0001;
      2'd1:    size_mask = 4'b0011;
      default: size_mask = 4'b1111;
    endcase
  endfunction

endpackage

// File: rtl/smc_stage_cmp.sv
module smc_stage_cmp #(
  parameter int unsigned AW    = 32,
  parameter int unsigned HWW   = 3,
  parameter int unsigned NBYTE = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    st_addr,
  input  logic [NBYTE-1:0] st_mask,
  input  logic             inst_vld,
  input  logic [AW-1:0]    inst_addr,
  input  logic [HWW-1:0]   inst_hw,
  output logic             hit_op,
  output logic             hit_imm
);

  localparam int unsigned LEN_W = HWW + 1;

  logic [LEN_W-1:0] len_bytes;
  assign len_bytes = {inst_hw, 1'b0};

  // Per store byte: distance from the instruction start, compared with its length
  always_comb begin
    logic [AW-1:0] off;
    hit_op  = 1'b0;
    hit_imm = 1'b0;
    for (int k = 0; k < NBYTE; k++) begin
      off = (st_addr + AW'(k)) - inst_addr;
      if (inst_vld && st_mask[k] && (off < AW'(len_bytes))) begin
        if (off < AW'(2)) hit_op  = 1'b1;
        else              hit_imm = 1'b1;
      end
    end
  end

  // R4: a one-halfword instruction has no extension bytes to hit
  p_imm_needs_ext_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hit_imm |-> (inst_hw > HWW'(1)));

endmodule

// File: rtl/smc_line_tags.sv
module smc_line_tags #(
  parameter int unsigned LINE_W = 28,
  parameter int unsigned NLINES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill_vld,
  input  logic [LINE_W-1:0] fill_line,
  input  logic              chk_vld,
  input  logic [LINE_W-1:0] chk_line,
  output logic              chk_hit
);

  localparam int unsigned IDX_W = $clog2(NLINES);
  localparam int unsigned TAG_W = LINE_W - IDX_W;

  logic [NLINES-1:0] valid_q, valid_d;
  logic [TAG_W-1:0]  tag_q [NLINES];

  logic [IDX_W-1:0] f_idx, c_idx;
  logic [TAG_W-1:0] f_tag, c_tag;

  assign f_idx = fill_line[IDX_W-1:0];
  assign f_tag = fill_line[LINE_W-1:IDX_W];
  assign c_idx = chk_line[IDX_W-1:0];
  assign c_tag = chk_line[LINE_W-1:IDX_W];

  assign chk_hit = chk_vld && valid_q[c_idx] && (tag_q[c_idx] == c_tag);

  // Fill sets, invalidate clears afterwards so it wins on the same line
  always_comb begin
    valid_d = valid_q;
    if (fill_vld) valid_d[f_idx] = 1'b1;
    if (chk_hit)  valid_d[c_idx] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (fill_vld) tag_q[f_idx] <= f_tag;
  end

  // R2: a line that was invalidated is not valid in the next cycle
  p_inv_clears_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
    chk_hit |=> !valid_q[$past(c_idx)]);

endmodule

// File: rtl/smc_oldest_pick.sv
module smc_oldest_pick #(
  parameter int unsigned NSTG = 6
) (
  input  logic [NSTG-1:0]         hit_op,
  input  logic [NSTG-1:0]         hit_imm,
  output logic                    any_hit,
  output logic [$clog2(NSTG)-1:0] sel,
  output logic [NSTG-1:0]         kill,
  output logic [1:0]              cls
);

  localparam int unsigned SEL_W = $clog2(NSTG);

  // Higher index = older stage; the last hit seen in ascending order wins
  always_comb begin
    any_hit = 1'b0;
    sel     = '0;
    for (int i = 0; i < NSTG; i++) begin
      if (hit_op[i] || hit_imm[i]) begin
        any_hit = 1'b1;
        sel     = SEL_W'(i);
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NSTG; i++) begin
      kill[i] = any_hit && (SEL_W'(i) <= sel);
    end
  end

  assign cls = any_hit ? {hit_op[sel], hit_imm[sel]} : 2'b00;

endmodule

// File: rtl/smc_hazard_det.sv
module smc_hazard_det
  import smc_pkg::*;
#(
  parameter int unsigned AW     = ADDR_W,
  parameter int unsigned NSTG   = N_STAGE,
  parameter int unsigned HWW    = HW_W,
  parameter int unsigned LINE_B = 16,
  parameter int unsigned NLINES = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          st_commit,
  input  logic [AW-1:0]                 st_addr,
  input  logic [1:0]                    st_size,
  input  logic [ST_BYTES-1:0]           st_be,
  input  logic [NSTG-1:0]               stg_vld,
  input  logic [NSTG*AW-1:0]            stg_addr,
  input  logic [NSTG*HWW-1:0]           stg_hw,
  input  logic                          fill_vld,
  input  logic [AW-$clog2(LINE_B)-1:0]  fill_line,
  output logic                          inv_vld,
  output logic [AW-$clog2(LINE_B)-1:0]  inv_line,
  output logic                          flush,
  output logic [AW-1:0]                 flush_addr,
  output logic [NSTG-1:0]               flush_kill,
  output logic [1:0]                    hz_class
);

  localparam int unsigned OFF_W  = $clog2(LINE_B);
  localparam int unsigned LINE_W = AW - OFF_W;
  localparam int unsigned SEL_W  = $clog2(NSTG);

  // ---------------- cache line check ----------------
  assign inv_line = st_addr[AW-1:OFF_W];

  smc_line_tags #(.LINE_W(LINE_W), .NLINES(NLINES)) u_tags (
    .clk       (clk),
    .rst_n     (rst_n),
    .fill_vld  (fill_vld),
    .fill_line (fill_line),
    .chk_vld   (st_commit),
    .chk_line  (st_addr[AW-1:OFF_W]),
    .chk_hit   (inv_vld)
  );

  // ---------------- per-stage overlap ----------------
  logic [ST_BYTES-1:0] st_mask;
  logic [NSTG-1:0]     hit_op, hit_imm;

  assign st_mask = st_be & size_mask(st_size);

  for (genvar g = 0; g < NSTG; g++) begin : g_stage
    smc_stage_cmp #(.AW(AW), .HWW(HWW), .NBYTE(ST_BYTES)) u_cmp (
      .clk       (clk),
      .rst_n     (rst_n),
      .st_addr   (st_addr),
      .st_mask   (st_mask),
      .inst_vld  (stg_vld[g]),
      .inst_addr (stg_addr[g*AW +: AW]),
      .inst_hw   (stg_hw[g*HWW +: HWW]),
      .hit_op    (hit_op[g]),
      .hit_imm   (hit_imm[g])
    );
  end

  logic             any_hit;
  logic [SEL_W-1:0] sel;
  logic [NSTG-1:0]  kill_c;
  logic [1:0]       cls_c;

  smc_oldest_pick #(.NSTG(NSTG)) u_pick (
    .hit_op  (hit_op),
    .hit_imm (hit_imm),
    .any_hit (any_hit),
    .sel     (sel),
    .kill    (kill_c),
    .cls     (cls_c)
  );

  // ---------------- flush request: next state ----------------
  logic            flush_q, flush_d;
  logic [AW-1:0]   raddr_q, raddr_d;
  logic [NSTG-1:0] kill_q, kill_d;
  logic [1:0]      cls_q, cls_d;
  logic            pipe_chk;

  assign pipe_chk = st_commit && !flush_q;

  always_comb begin
    flush_d = pipe_chk && any_hit;
    raddr_d = '0;
    kill_d  = '0;
    cls_d   = HZ_NONE;
    if (flush_d) begin
      raddr_d = stg_addr[sel*AW +: AW];
      kill_d  = kill_c;
      cls_d   = cls_c;
    end
  end

  // ---------------- flush request: registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flush_q <= 1'b0;
      raddr_q <= '0;
      kill_q  <= '0;
      cls_q   <= HZ_NONE;
    end else begin
      flush_q <= flush_d;
      raddr_q <= raddr_d;
      kill_q  <= kill_d;
      cls_q   <= cls_d;
    end
  end

  assign flush      = flush_q;
  assign flush_addr = raddr_q;
  assign flush_kill = kill_q;
  assign hz_class   = cls_q;

  // ---------------- assertions ----------------
  p_flush_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !flush);

  p_flush_follows_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> $past(st_commit));

  p_no_flush_in_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && st_commit) |=> !flush);

  p_class_with_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (hz_class != HZ_NONE));

  p_class_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |-> (hz_class == HZ_NONE && flush_kill == '0));

  p_kill_shape_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (flush_kill[0] && ((flush_kill & (flush_kill + 1'b1)) == '0)));

  p_inv_needs_commit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    inv_vld |-> st_commit);

endmodule

// File: tb/test_smc_hazard_det.sv
module test_smc_hazard_det;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         st_commit;
  logic [31:0]  st_addr;
  logic [1:0]   st_size;
  logic [3:0]   st_be;
  logic [5:0]   stg_vld;
  logic [191:0] stg_addr;
  logic [17:0]  stg_hw;
  logic         fill_vld;
  logic [27:0]  fill_line;
  logic         inv_vld;
  logic [27:0]  inv_line;
  logic         flush;
  logic [31:0]  flush_addr;
  logic [5:0]   flush_kill;
  logic [1:0]   hz_class;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  smc_hazard_det i_smc_hazard_det (
    .clk(clk), .rst_n(rst_n), .st_commit(st_commit), .st_addr(st_addr),
    .st_size(st_size), .st_be(st_be), .stg_vld(stg_vld), .stg_addr(stg_addr),
    .stg_hw(stg_hw), .fill_vld(fill_vld), .fill_line(fill_line),
    .inv_vld(inv_vld), .inv_line(inv_line), .flush(flush),
    .flush_addr(flush_addr), .flush_kill(flush_kill), .hz_class(hz_class)
  );

  typedef struct packed {
    logic [31:0] a;
    logic [1:0]  sz;
    logic [3:0]  be;
    logic        fl;
    logic [1:0]  cls;
    logic [31:0] rs;
    logic [5:0]  kl;
  } vec_t;

  // Stage layout: s5 1000/3hw s4 1006/1 s3 1008/5 s2 1012/2 s1 1016/1 s0 1018/4
  localparam vec_t VEC [10] = '{
    '{32'h1004, 2'd1, 4'b0011, 1'b1, 2'b01, 32'h1000, 6'b111111},
    '{32'h1006, 2'd0, 4'b0001, 1'b1, 2'b10, 32'h1006, 6'b011111},
    '{32'h1010, 2'd2, 4'b1111, 1'b1, 2'b01, 32'h1008, 6'b001111},
    '{32'h1008, 2'd2, 4'b1111, 1'b1, 2'b11, 32'h1008, 6'b001111},
    '{32'h1020, 2'd2, 4'b1111, 1'b0, 2'b00, 32'h0,    6'b000000},
    '{32'h1014, 2'd1, 4'b0010, 1'b1, 2'b01, 32'h1012, 6'b000111},
    '{32'h1014, 2'd1, 4'b1100, 1'b0, 2'b00, 32'h0,    6'b000000},
    '{32'h1018, 2'd0, 4'b0001, 1'b1, 2'b10, 32'h1018, 6'b000001},
    '{32'h1004, 2'd2, 4'b1100, 1'b1, 2'b10, 32'h1006, 6'b011111},
    '{32'h1000, 2'd0, 4'b1111, 1'b1, 2'b10, 32'h1000, 6'b111111}
  };

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic set_stages();
    logic [31:0] a [6] = '{32'h1018, 32'h1016, 32'h1012, 32'h1008, 32'h1006, 32'h1000};
    logic [2:0]  h [6] = '{3'd4, 3'd1, 3'd2, 3'd5, 3'd1, 3'd3};
    for (int i = 0; i < 6; i++) begin
      stg_addr[i*32 +: 32] = a[i];
      stg_hw[i*3 +: 3]     = h[i];
    end
    stg_vld = 6'b111111;
  endtask

  task automatic do_fill(logic [31:0] addr);
    @(negedge clk);
    st_commit = 1'b0;
    fill_vld  = 1'b1;
    fill_line = addr[31:4];
    @(negedge clk);
    fill_vld  = 1'b0;
  endtask

  // Drive one store on a negedge; the caller samples inv at once, flush after the edge
  task automatic put_store(logic [31:0] a, logic [1:0] sz, logic [3:0] be);
    st_commit = 1'b1;
    st_addr   = a;
    st_size   = sz;
    st_be     = be;
    #1;
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; st_commit = 1'b0; st_addr = '0; st_size = '0; st_be = '0;
    fill_vld = 1'b0; fill_line = '0; stg_addr = '0; stg_hw = '0; stg_vld = '0;
    set_stages();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10: reset state
    chk("R10", "flush", 32'(flush), 0);
    chk("R10", "class", 32'(hz_class), 0);
    chk("R10", "kill", 32'(flush_kill), 0);
    chk("R10", "restart", flush_addr, 0);
    // R10/R1: no line valid after reset, so a store invalidates nothing
    put_store(32'h1000, 2'd0, 4'b0001);
    chk("R10", "inv after reset", 32'(inv_vld), 0);
    @(posedge clk); #1;
    chk("R5", "flush raised", 32'(flush), 1);
    @(negedge clk); st_commit = 1'b0;
    @(posedge clk); #1;
    chk("R5", "flush one cycle", 32'(flush), 0);

    // Table walk: R1 R3 R4 R6 R7 R8 R11
    for (int v = 0; v < 10; v++) begin
      do_fill(VEC[v].a);
      put_store(VEC[v].a, VEC[v].sz, VEC[v].be);
      chk("R1", $sformatf("v%0d inv", v), 32'(inv_vld), 1);
      chk("R1", $sformatf("v%0d line", v), 32'(inv_line), 32'(VEC[v].a[31:4]));
      @(posedge clk); #1;
      chk("R5", $sformatf("v%0d flush", v), 32'(flush), 32'(VEC[v].fl));
      chk("R8", $sformatf("v%0d class", v), 32'(hz_class), 32'(VEC[v].cls));
      chk("R6", $sformatf("v%0d restart", v), flush_addr, VEC[v].rs);
      chk("R7", $sformatf("v%0d kill", v), 32'(flush_kill), 32'(VEC[v].kl));
    end

    // R4: invalid stage is ignored
    @(negedge clk); st_commit = 1'b0; stg_vld = 6'b011111;
    @(negedge clk);
    put_store(32'h1000, 2'd0, 4'b0001);
    @(posedge clk); #1;
    chk("R4", "invalid stage no flush", 32'(flush), 0);
    @(negedge clk); st_commit = 1'b0; stg_vld = 6'b111111;

    // R1: alias on index 0 with a different tag
    do_fill(32'h1000);
    put_store(32'h1080, 2'd2, 4'b1111);
    chk("R1", "alias no inv", 32'(inv_vld), 0);
    @(posedge clk); #1;
    chk("R11", "far store no flush", 32'(flush), 0);

    // R9: second overlapping store during the flush cycle
    do_fill(32'h1010);
    put_store(32'h1000, 2'd0, 4'b0001);
    chk("R1", "first store inv", 32'(inv_vld), 1);
    @(posedge clk); #1;
    chk("R9", "first flush", 32'(flush), 1);
    @(negedge clk);
    put_store(32'h1010, 2'd0, 4'b0001);
    chk("R9", "inv during flush", 32'(inv_vld), 1);
    chk("R9", "inv line during flush", 32'(inv_line), 32'h101);
    @(posedge clk); #1;
    chk("R9", "no flush from suppressed store", 32'(flush), 0);

    // R2: fill and invalidate on the same line in one cycle
    do_fill(32'h1040);
    @(negedge clk);
    fill_vld = 1'b1; fill_line = 28'h104;
    put_store(32'h1040, 2'd2, 4'b1111);
    chk("R2", "inv with concurrent fill", 32'(inv_vld), 1);
    @(negedge clk);
    fill_vld = 1'b0; st_commit = 1'b0;
    @(negedge clk);
    put_store(32'h1044, 2'd2, 4'b1111);
    chk("R2", "invalidate wins over fill", 32'(inv_vld), 0);
    @(negedge clk); st_commit = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule